// File: doc/BRIEF.md
# Masked Even-Lane Duplicating Vector Unit

This unit is one stage of a vector datapath. It takes a 512-bit source made of sixteen 32-bit lanes. Within every adjacent pair of lanes, it copies the lower (even-numbered) element into both positions of the pair. The lanes are treated as raw bit patterns, so any encoding passes through untouched, including NaN payloads. The duplicated vector is then merged into the current destination value, following the selected encoding mode. The merged value is presented one clock later, with a one-cycle output strobe.

There are four modes:
- **Legacy 128-bit:** leaves everything above bit 127 as it was.
- **Plain 128-bit and 256-bit:** clear everything above their length.
- **Masked:** takes its length from a separate length code. It applies a 16-bit per-lane writemask, with either merge or zero behaviour, and clears everything above the active length.

Every request also carries a 4-bit reserved specifier field that must be all ones. A wrong specifier, or an illegal length for the mode, raises an undefined-instruction fault. In that case the destination is returned unmodified.

Top module: `evdup_unit`

## Requirements
- R1: For every lane pair (2m, 2m+1) inside the active length, both result lanes equal source lane 2m, bit for bit (NaN patterns included).
- R2: `out_valid`, `result` and `ud_fault` update on the clock edge that samples `in_valid`=1. `out_valid` is high for exactly that one cycle. When `in_valid` is 0, `out_valid` is 0 on the next cycle and `result`/`ud_fault` hold their values.
- R3: After a synchronous reset (`rst_n`=0), `out_valid`=0, `ud_fault`=0 and `result`=0.
- R4: If `rsvd_spec` is not 4'b1111, `ud_fault`=1 and `result` equals `dst_old` unchanged, in any mode.
- R5: Mode 2'b00 (legacy 128) writes lanes 0..3 and returns lanes 4..15 from `dst_old`.
- R6: Mode 2'b01 (plain 128) writes lanes 0..3 and zeroes lanes 4..15. Mode 2'b10 (plain 256) writes lanes 0..7 and zeroes lanes 8..15.
- R7: In modes 2'b00, 2'b01 and 2'b10, the inputs `wmask`, `mask_en` and `zero_mask` have no effect, and neither do the length codes 2'b00/2'b01.
- R8: In modes 2'b00, 2'b01 and 2'b10, a length code of 2'b10 (512) or 2'b11 (reserved) raises `ud_fault` and returns `dst_old`.
- R9: In mode 2'b11 (masked), the length code 2'b00/2'b01/2'b10 selects 4/8/16 active lanes, and lanes beyond the active count are zero. Length code 2'b11 raises `ud_fault` and returns `dst_old`.
- R10: In masked mode with `mask_en`=1, an active lane j with `wmask[j]`=1 takes the duplicated value. If `wmask[j]`=0, the lane keeps `dst_old` when `zero_mask`=0, or becomes zero when `zero_mask`=1.
- R11: In masked mode with `mask_en`=0, every active lane takes the duplicated value, whatever `wmask` and `zero_mask` are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| mode | input | 2 | 00 legacy 128, 01 plain 128, 10 plain 256, 11 masked |
| vlen | input | 2 | Length code: 00=128, 01=256, 10=512, 11 reserved |
| mask_en | input | 1 | Masked mode: 1 applies `wmask` |
| zero_mask | input | 1 | 1 zeroes unselected lanes, 0 keeps them |
| wmask | input | 16 | Per-lane writemask, bit j for lane j |
| rsvd_spec | input | 4 | Reserved specifier, must be 1111 |
| src | input | 512 | Source vector, lane j at bits 32j+31:32j |
| dst_old | input | 512 | Current destination value |
| out_valid | output | 1 | One-cycle result strobe |
| result | output | 512 | New destination value |
| ud_fault | output | 1 | Undefined-instruction fault |

## Verification
The source gives every lane a distinct value whose odd lanes differ from their even neighbours. A copy from the wrong lane, or an unduplicated odd lane, therefore shows up directly. The old destination uses another distinct pattern, so kept lanes, zeroed lanes and written lanes can all be told apart. The writemasks are alternating, sparse and all-ones, which separates merge from zero behaviour per lane. The same requests are repeated with changed don't-care inputs and with each bad specifier or length code. This shows which inputs are ignored and that a fault leaves the destination intact.

// File: rtl/evdup_pkg.sv
// Package: shared encodings for the even-lane duplicating vector unit.
// Assumes a lane count that is even and at least 8.
package evdup_pkg;
    parameter int unsigned LANE_W    = 32;
    parameter int unsigned NUM_LANES = 16;

    typedef enum logic [1:0] {
        MODE_LEG128 = 2'b00,
        MODE_V128   = 2'b01,
        MODE_V256   = 2'b10,
        MODE_MASKED = 2'b11
    } mode_e;

    typedef enum logic [1:0] {
        VL_128  = 2'b00,
        VL_256  = 2'b01,
        VL_512  = 2'b10,
        VL_RSVD = 2'b11
    } vlen_e;

    typedef enum logic [1:0] {
        SEL_DUP  = 2'b00,
        SEL_OLD  = 2'b01,
        SEL_ZERO = 2'b10
    } lane_sel_e;

    localparam logic [3:0] SPEC_OK = 4'b1111;
endpackage

// File: rtl/evdup_pair_dup.sv
// Module: evdup_pair_dup
// Copies the even lane of every lane pair into both lanes of the pair.
// Purely combinational; assumes NUM_LANES is even.
module evdup_pair_dup #(
    parameter int unsigned LANE_W    = 32,
    parameter int unsigned NUM_LANES = 16,
    localparam int unsigned VEC_W    = LANE_W * NUM_LANES
) (
    input  logic [VEC_W-1:0] src,
    output logic [VEC_W-1:0] dup
);
    localparam int unsigned NUM_PAIRS = NUM_LANES / 2;

    // One copy network per lane pair.
    for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
        assign dup[(2*p)*LANE_W   +: LANE_W] = src[(2*p)*LANE_W +: LANE_W];
        assign dup[(2*p+1)*LANE_W +: LANE_W] = src[(2*p)*LANE_W +: LANE_W];
    end
endmodule

// File: rtl/evdup_ctrl.sv
// Module: evdup_ctrl
// Decodes the mode, length code, mask controls and reserved specifier into
// a fault flag and one select code per lane (duplicate, keep old, zero).
// Assumes 128 and 256 bits are whole multiples of LANE_W.
module evdup_ctrl
    import evdup_pkg::*;
#(
    parameter int unsigned LANE_W    = 32,
    parameter int unsigned NUM_LANES = 16
) (
    input  mode_e                           mode,
    input  vlen_e                           vlen,
    input  logic                            mask_en,
    input  logic                            zero_mask,
    input  logic [NUM_LANES-1:0]            wmask,
    input  logic [3:0]                      rsvd_spec,
    output logic                            fault,
    output lane_sel_e [NUM_LANES-1:0]       sel
);
    localparam int unsigned CNT_W  = $clog2(NUM_LANES + 1);
    localparam int unsigned L128   = 128 / LANE_W;
    localparam int unsigned L256   = 256 / LANE_W;
    localparam logic [CNT_W-1:0] N128 = CNT_W'(L128);
    localparam logic [CNT_W-1:0] N256 = CNT_W'(L256);
    localparam logic [CNT_W-1:0] NALL = CNT_W'(NUM_LANES);

    logic [CNT_W-1:0] n_active;
    logic             len_bad;
    logic             spec_bad;
    logic             masked;
    logic             keep_upper;

    // Active lane count and length legality per mode.
    always_comb begin
        n_active = N128;
        len_bad  = 1'b0;
        case (mode)
            MODE_LEG128: begin n_active = N128; len_bad = vlen[1]; end
            MODE_V128:   begin n_active = N128; len_bad = vlen[1]; end
            MODE_V256:   begin n_active = N256; len_bad = vlen[1]; end
            default: begin
                len_bad = (vlen == VL_RSVD);
                case (vlen)
                    VL_128:  n_active = N128;
                    VL_256:  n_active = N256;
                    default: n_active = NALL;
                endcase
            end
        endcase
    end

    // Fault and mode flags shared by all lanes.
    always_comb begin
        spec_bad   = (rsvd_spec != SPEC_OK);
        fault      = spec_bad | len_bad;
        masked     = (mode == MODE_MASKED);
        keep_upper = (mode == MODE_LEG128);
    end

    // Per-lane select code.
    for (genvar j = 0; j < NUM_LANES; j++) begin : g_lane
        logic active;
        logic wr;
        always_comb begin
            active = (CNT_W'(j) < n_active);
            wr     = !masked || !mask_en || wmask[j];
            if (fault)
                sel[j] = SEL_OLD;
            else if (active)
                sel[j] = wr ? SEL_DUP : (zero_mask ? SEL_ZERO : SEL_OLD);
            else
                sel[j] = keep_upper ? SEL_OLD : SEL_ZERO;
        end
    end

    // A faulting request must never write any lane.
    always_comb begin
        if (fault) begin
            AST_FAULT_NO_WRITE: assert (sel[0] == SEL_OLD && sel[NUM_LANES-1] == SEL_OLD); // R4
        end
    end
endmodule

// File: rtl/evdup_lane_mux.sv
// Module: evdup_lane_mux
// Chooses each output lane from the duplicated source, the old destination
// or zero, following the per-lane select code.
module evdup_lane_mux
    import evdup_pkg::*;
#(
    parameter int unsigned LANE_W    = 32,
    parameter int unsigned NUM_LANES = 16,
    localparam int unsigned VEC_W    = LANE_W * NUM_LANES
) (
    input  logic [VEC_W-1:0]          dup,
    input  logic [VEC_W-1:0]          old,
    input  lane_sel_e [NUM_LANES-1:0] sel,
    output logic [VEC_W-1:0]          merged
);
    // One three-way lane selector per lane.
    for (genvar j = 0; j < NUM_LANES; j++) begin : g_lane
        always_comb begin
            case (sel[j])
                SEL_DUP:  merged[j*LANE_W +: LANE_W] = dup[j*LANE_W +: LANE_W];
                SEL_OLD:  merged[j*LANE_W +: LANE_W] = old[j*LANE_W +: LANE_W];
                default:  merged[j*LANE_W +: LANE_W] = '0;
            endcase
        end
    end
endmodule

// File: rtl/evdup_unit.sv
// Module: evdup_unit (top)
// Even-lane duplicating vector unit: duplicate, decode, merge, then one
// output register stage. Assumes 32-bit lanes and a 16-lane vector by default.
module evdup_unit
    import evdup_pkg::*;
#(
    parameter int unsigned LANE_W    = 32,
    parameter int unsigned NUM_LANES = 16,
    localparam int unsigned VEC_W    = LANE_W * NUM_LANES,
    localparam int unsigned LOW_W    = 128
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic [1:0]           mode,
    input  logic [1:0]           vlen,
    input  logic                 mask_en,
    input  logic                 zero_mask,
    input  logic [NUM_LANES-1:0] wmask,
    input  logic [3:0]           rsvd_spec,
    input  logic [VEC_W-1:0]     src,
    input  logic [VEC_W-1:0]     dst_old,
    output logic                 out_valid,
    output logic [VEC_W-1:0]     result,
    output logic                 ud_fault
);
    logic [VEC_W-1:0]          dup;
    logic [VEC_W-1:0]          merged;
    lane_sel_e [NUM_LANES-1:0] sel;
    logic                      fault;

    evdup_pair_dup #(.LANE_W(LANE_W), .NUM_LANES(NUM_LANES)) u_dup (
        .src (src),
        .dup (dup)
    );

    evdup_ctrl #(.LANE_W(LANE_W), .NUM_LANES(NUM_LANES)) u_ctrl (
        .mode      (mode_e'(mode)),
        .vlen      (vlen_e'(vlen)),
        .mask_en   (mask_en),
        .zero_mask (zero_mask),
        .wmask     (wmask),
        .rsvd_spec (rsvd_spec),
        .fault     (fault),
        .sel       (sel)
    );

    evdup_lane_mux #(.LANE_W(LANE_W), .NUM_LANES(NUM_LANES)) u_mux (
        .dup    (dup),
        .old    (dst_old),
        .sel    (sel),
        .merged (merged)
    );

    // Output register: capture on a request, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            result    <= '0;
            ud_fault  <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                result   <= merged;
                ud_fault <= fault;
            end
        end
    end

    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R2
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(result))); // R2
    AST_SPEC_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && rsvd_spec != SPEC_OK) |=> (ud_fault && result == $past(dst_old))); // R4
    AST_PAIR_EQUAL: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && rsvd_spec == SPEC_OK && mode != 2'b11 && !vlen[1])
        |=> result[2*LANE_W-1:LANE_W] == $past(src[LANE_W-1:0])); // R1
    AST_LEGACY_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode == 2'b00)
        |=> result[VEC_W-1:LOW_W] == $past(dst_old[VEC_W-1:LOW_W])); // R5
    AST_V128_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode == 2'b01 && rsvd_spec == SPEC_OK && !vlen[1])
        |=> result[VEC_W-1:LOW_W] == '0); // R6
endmodule

// File: tb/evdup_unit_test.sv
// Directed bench for evdup_unit: one task per scenario, each checking itself.
module evdup_unit_test;
    localparam int LW = 32;
    localparam int NL = 16;
    localparam int VW = LW * NL;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          in_valid;
    logic [1:0]    mode;
    logic [1:0]    vlen;
    logic          mask_en;
    logic          zero_mask;
    logic [NL-1:0] wmask;
    logic [3:0]    rsvd_spec;
    logic [VW-1:0] src;
    logic [VW-1:0] dst_old;
    logic          out_valid;
    logic [VW-1:0] result;
    logic          ud_fault;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #5 clk = ~clk;

    evdup_unit uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode(mode), .vlen(vlen),
        .mask_en(mask_en), .zero_mask(zero_mask), .wmask(wmask), .rsvd_spec(rsvd_spec),
        .src(src), .dst_old(dst_old), .out_valid(out_valid), .result(result),
        .ud_fault(ud_fault)
    );

    // Expected value from the requirements.
    function automatic void model(input logic [1:0] md, input logic [1:0] vl,
                                  input logic me, input logic zm, input logic [NL-1:0] wm,
                                  input logic [3:0] sp, input logic [VW-1:0] s,
                                  input logic [VW-1:0] o, output logic [VW-1:0] r,
                                  output logic f);
        int n;
        f = (sp != 4'hF);                               // R4
        if (md != 2'b11) begin
            f = f | vl[1];                              // R8
            n = (md == 2'b10) ? 8 : 4;                  // R5 R6
        end else begin
            f = f | (vl == 2'b11);                      // R9
            n = (vl == 2'b00) ? 4 : (vl == 2'b01) ? 8 : 16;
        end
        r = o;
        if (f) return;
        for (int j = 0; j < NL; j++) begin
            logic [LW-1:0] d;
            d = s[(j - (j % 2))*LW +: LW];              // R1
            if (j < n) begin
                if (md != 2'b11 || !me || wm[j]) r[j*LW +: LW] = d;   // R10 R11
                else if (zm) r[j*LW +: LW] = '0;
            end else if (md != 2'b00) begin
                r[j*LW +: LW] = '0;                     // R6 R9
            end
        end
    endfunction

    task automatic check(input string req, input logic [VW-1:0] act, input logic [VW-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Issue one request and compare the registered output one cycle later.
    task automatic run(input string req, input logic [1:0] md, input logic [1:0] vl,
                       input logic me, input logic zm, input logic [NL-1:0] wm,
                       input logic [3:0] sp);
        logic [VW-1:0] er;
        logic ef;
        @(negedge clk);
        mode = md; vlen = vl; mask_en = me; zero_mask = zm; wmask = wm; rsvd_spec = sp;
        in_valid = 1'b1;
        model(md, vl, me, zm, wm, sp, src, dst_old, er, ef);
        @(negedge clk);
        in_valid = 1'b0;
        check({req, " out_valid"}, VW'(out_valid), VW'(1'b1));
        check({req, " result"}, result, er);
        check({req, " ud_fault"}, VW'(ud_fault), VW'(ef));
    endtask

    task automatic load_patterns;
        for (int j = 0; j < NL; j++) begin
            src[j*LW +: LW]     = {8'hA0 + 8'(j), 8'h11, 8'h00 + 8'(j), 8'h5C};
            dst_old[j*LW +: LW] = {8'h30 + 8'(j), 8'hEE, 8'hD0, 8'(j)};
        end
        src[2*LW +: LW] = 32'h7FC0_0123;                // NaN payload, R1
    endtask

    task automatic t_reset;                              // R3
        rst_n = 1'b0; in_valid = 1'b0; mode = '0; vlen = '0; mask_en = 0;
        zero_mask = 0; wmask = '0; rsvd_spec = 4'hF;
        load_patterns();
        repeat (3) @(negedge clk);
        check("R3 out_valid", VW'(out_valid), '0);
        check("R3 result", result, '0);
        check("R3 ud_fault", VW'(ud_fault), '0);
        rst_n = 1'b1;
    endtask

    task automatic t_unmasked_modes;
        run("R5 legacy", 2'b00, 2'b00, 0, 0, 16'h0000, 4'hF);
        run("R6 v128", 2'b01, 2'b00, 0, 0, 16'h0000, 4'hF);
        run("R6 v256", 2'b10, 2'b01, 0, 0, 16'h0000, 4'hF);
        run("R1 v256 dup", 2'b10, 2'b00, 0, 0, 16'h0000, 4'hF);
    endtask

    task automatic t_ignored_inputs;                     // R7
        run("R7 v128 mask ignored", 2'b01, 2'b01, 1, 1, 16'h0000, 4'hF);
        run("R7 legacy mask ignored", 2'b00, 2'b01, 1, 0, 16'h5A5A, 4'hF);
        run("R7 v256 mask ignored", 2'b10, 2'b00, 1, 1, 16'h0001, 4'hF);
    endtask

    task automatic t_length_faults;
        run("R8 legacy vl512", 2'b00, 2'b10, 0, 0, 16'h0000, 4'hF);
        run("R8 v256 vlrsvd", 2'b10, 2'b11, 0, 0, 16'h0000, 4'hF);
        run("R9 masked vlrsvd", 2'b11, 2'b11, 1, 1, 16'hFFFF, 4'hF);
    endtask

    task automatic t_spec_faults;                        // R4
        run("R4 spec 0111", 2'b11, 2'b10, 0, 0, 16'hFFFF, 4'h7);
        run("R4 spec 0000", 2'b01, 2'b00, 0, 0, 16'h0000, 4'h0);
        run("R4 spec 1110", 2'b00, 2'b00, 0, 0, 16'h0000, 4'hE);
    endtask

    task automatic t_masked;
        run("R9 masked 128", 2'b11, 2'b00, 0, 0, 16'h0000, 4'hF);
        run("R9 masked 256", 2'b11, 2'b01, 0, 1, 16'h0000, 4'hF);
        run("R11 masked 512 nomask", 2'b11, 2'b10, 0, 1, 16'h0000, 4'hF);
        run("R10 merge alt", 2'b11, 2'b10, 1, 0, 16'hAAAA, 4'hF);
        run("R10 zero alt", 2'b11, 2'b10, 1, 1, 16'h5555, 4'hF);
        run("R10 zero sparse 256", 2'b11, 2'b01, 1, 1, 16'h0081, 4'hF);
        run("R10 merge all", 2'b11, 2'b10, 1, 0, 16'hFFFF, 4'hF);
    endtask

    task automatic t_idle;                               // R2
        logic [VW-1:0] held;
        run("R2 setup", 2'b01, 2'b00, 0, 0, 16'h0000, 4'hF);
        held = result;
        src = ~src;
        @(negedge clk);
        check("R2 out_valid idle", VW'(out_valid), '0);
        check("R2 result held", result, held);
        src = ~src;
    endtask

    initial begin
        t_reset();
        t_unmasked_modes();
        t_ignored_inputs();
        t_length_faults();
        t_spec_faults();
        t_masked();
        t_idle();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule